// File: doc/BRIEF.md
# Maskable Interrupt Pin Combiner

This block merges four internal interrupt status flags into a single active-low interrupt pin for a host. The four flags are a key event, a general input change, a logic block output and a FIFO overflow. Each flag has its own enable bit, and a flag counts only while its enable bit is set. The pin is driven low whenever at least one enabled flag is active, and it returns high once none are.

A mode input sets what happens when one enabled flag drops while another is still active. In level mode the pin stays low and the host sees no change. In pulse mode the pin is released high for a fixed 50 µs and then pulled low again, so that a host sensitive only to falling edges is told that work is still pending. The release length is counted in clock cycles. It is derived from a clock-frequency parameter and a release-time parameter. The pin output comes straight from a flop.

Top module: `intr_pin_combiner`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls when no enabled flag is active, `irq_n` is 1.
- R2: An enabled flag is one where `src_flag[i]` and `src_en[i]` are both 1. The bit order is: bit 0 key event, bit 1 general input, bit 2 logic block, bit 3 FIFO overflow. A flag whose enable bit is 0 has no effect on `irq_n`. When the pin is idle and not releasing, `irq_n` goes to 0 at the first clock edge at which an enabled flag is active.
- R3: With `pulse_mode` = 0 and `irq_n` low, `irq_n` stays 0 as long as any enabled flag is active, even when other enabled flags drop.
- R4: When no enabled flag is active, `irq_n` is 1 after the next clock edge and stays 1 with no later reassertion. This also applies during a release.
- R5: With `pulse_mode` = 1 and `irq_n` low, suppose at least one previously enabled flag is no longer enabled-active at a clock edge while another still is. Then `irq_n` goes to 1 at that edge.
- R6: A release keeps `irq_n` high for exactly REL_CYC cycles, where REL_CYC = CLK_FREQ_HZ × RELEASE_US / 10^6. The default is 10000 cycles at 200 MHz and 50 µs. After that, `irq_n` returns to 0 if any enabled flag is still active.
- R7: During a release, the release neither ends early nor gets longer if flags rise or fall, provided at least one enabled flag stays active.
- R8: Clearing `src_en[i]` while `src_flag[i]` is 1 has the same effect as that flag dropping. In pulse mode, with other flags active, this starts a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_FREQ_HZ |
| rst | input | 1 | Synchronous reset, active high |
| src_flag | input | 4 | Interrupt status flags (bit 0 key, 1 general input, 2 logic, 3 overflow) |
| src_en | input | 4 | Per-flag enable bits, same bit order |
| pulse_mode | input | 1 | 0: hold pin low on partial clear; 1: release for RELEASE_US then reassert |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions assume that `src_flag`, `src_en` and `pulse_mode` are synchronous to `clk` and stable at each edge. They also assume that a drop is judged against enabled-active flags registered from the previous cycle, starting from zero after reset. The bench changes every input only at the falling clock edge. It holds random patterns for 1 to 40 cycles, and it mixes in long directed holds so that complete 10000-cycle releases are observed, including flags that rise, fall or lose their enable bit inside a release.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int unsigned NUM_SRC = 4;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_ASSERT  = 2'd1,
        PS_RELEASE = 2'd2
    } pin_state_e;

    typedef struct packed {
        logic any_active;
        logic some_dropped;
    } src_summary_t;

    // Release length in cycles, never below one.
    function automatic int unsigned release_cycles(input longint unsigned freq_hz,
                                                   input longint unsigned rel_us);
        longint unsigned cyc;
        cyc = ((freq_hz / 64'd1000) * rel_us) / 64'd1000;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc[31:0]);
    endfunction

endpackage

// File: rtl/intr_src_gate.sv
module intr_src_gate
    import intr_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    output src_summary_t    summary
);
    logic [NSRC-1:0] act;
    logic [NSRC-1:0] act_q;
    logic [NSRC-1:0] drop;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign act[i]  = flag[i] & en[i];
        assign drop[i] = act_q[i] & ~act[i];
        always_ff @(posedge clk) begin
            if (rst) act_q[i] <= 1'b0;
            else     act_q[i] <= act[i];
        end
    end

    assign summary.any_active   = |act;
    assign summary.some_dropped = |drop;
endmodule

// File: rtl/intr_release_timer.sv
module intr_release_timer #(
    parameter int unsigned REL_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic expire
);
    localparam int unsigned CW = (REL_CYC > 1) ? $clog2(REL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(REL_CYC - 1);

    logic [CW-1:0] cnt;
    logic          running;

    assign expire = running && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (cancel || expire) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/intr_pin_fsm.sv
module intr_pin_fsm
    import intr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  src_summary_t summary,
    input  logic         pulse_mode,
    input  logic         expire,
    output logic         tmr_start,
    output logic         tmr_cancel,
    output logic         releasing,
    output logic         pin_n
);
    pin_state_e st, nxt;

    always_comb begin
        nxt        = st;
        tmr_start  = 1'b0;
        tmr_cancel = 1'b0;
        unique case (st)
            PS_IDLE: begin
                if (summary.any_active) nxt = PS_ASSERT;
            end
            PS_ASSERT: begin
                if (!summary.any_active) begin
                    nxt = PS_IDLE;
                end else if (pulse_mode && summary.some_dropped) begin
                    nxt       = PS_RELEASE;
                    tmr_start = 1'b1;
                end
            end
            PS_RELEASE: begin
                if (!summary.any_active) begin
                    nxt        = PS_IDLE;
                    tmr_cancel = 1'b1;
                end else if (expire) begin
                    nxt = PS_ASSERT;
                end
            end
            default: nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PS_IDLE;
            pin_n <= 1'b1;
        end else begin
            st    <= nxt;
            pin_n <= (nxt != PS_ASSERT);
        end
    end

    assign releasing = (st == PS_RELEASE);
endmodule

// File: rtl/intr_pin_combiner.sv
module intr_pin_combiner
    import intr_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 200_000_000,
    parameter longint unsigned RELEASE_US  = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               pulse_mode,
    output logic               irq_n
);
    localparam int unsigned REL_CYC = release_cycles(CLK_FREQ_HZ, RELEASE_US);

    src_summary_t summary;
    logic         expire, tmr_start, tmr_cancel, rel_busy;

    intr_src_gate #(.NSRC(NUM_SRC)) u_gate (
        .clk(clk), .rst(rst), .flag(src_flag), .en(src_en), .summary(summary)
    );

    intr_release_timer #(.REL_CYC(REL_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(tmr_start), .cancel(tmr_cancel), .expire(expire)
    );

    intr_pin_fsm u_fsm (
        .clk(clk), .rst(rst), .summary(summary), .pulse_mode(pulse_mode),
        .expire(expire), .tmr_start(tmr_start), .tmr_cancel(tmr_cancel),
        .releasing(rel_busy), .pin_n(irq_n)
    );
endmodule

// File: rtl/intr_pin_checker.sv
module intr_pin_checker #(
    parameter int unsigned NSRC    = 4,
    parameter int unsigned REL_CYC = 10000
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_flag,
    input logic [NSRC-1:0] src_en,
    input logic            pulse_mode,
    input logic            rel_busy,
    input logic            irq_n
);
    localparam int unsigned LW = $clog2(REL_CYC + 1) + 1;

    logic [NSRC-1:0] act, chk_prev;
    logic [LW-1:0]   rel_len;

    assign act = src_flag & src_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_prev <= '0;
            rel_len  <= '0;
        end else begin
            chk_prev <= act;
            rel_len  <= rel_busy ? rel_len + 1'b1 : '0;
        end
    end

    AST_RESET_HIGH: assert property (@(posedge clk) rst |=> irq_n); // R1

    AST_ASSERT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !rel_busy && |act) |=> !irq_n); // R2

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pulse_mode && !irq_n && |act) |=> !irq_n); // R3

    AST_QUIET_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |=> (irq_n && !rel_busy)); // R4

    AST_PARTIAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && !irq_n && |act && |(chk_prev & ~act)) |=> irq_n); // R5

    AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (rel_busy && rel_len == LW'(REL_CYC - 1)) |=> !rel_busy); // R6

    AST_RELEASE_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (rel_busy && rel_len < LW'(REL_CYC - 1) && |act) |=> (rel_busy && irq_n)); // R7

    always_ff @(posedge clk) begin
        if (!rst) AST_RELEASE_BOUND: assert (rel_len <= LW'(REL_CYC)); // R6
    end
endmodule

bind intr_pin_combiner intr_pin_checker #(.NSRC(intr_pkg::NUM_SRC), .REL_CYC(REL_CYC)) u_chk (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
    .pulse_mode(pulse_mode), .rel_busy(rel_busy), .irq_n(irq_n)
);

// File: tb/intr_pin_combiner_tb.sv
`timescale 1ns/1ps
module intr_pin_combiner_tb;
    localparam int REL = 10000; // 200 MHz x 50 us

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_flag = '0;
    logic [3:0] src_en   = '0;
    logic       pulse_mode = 1'b0;
    logic       irq_n;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    intr_pin_combiner u_dut (
        .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
        .pulse_mode(pulse_mode), .irq_n(irq_n)
    );

    // Reference model built from the requirements: 0 idle, 1 low, 2 release
    int         m_st = 0, m_cnt = 0;
    logic [3:0] m_prev = '0;
    always @(posedge clk) begin
        logic [3:0] a;
        cyc++;
        a = src_flag & src_en;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_prev = '0;
        end else begin
            case (m_st)
                0: if (a != 0) m_st = 1;
                1: if (a == 0) m_st = 0;
                   else if (pulse_mode && ((m_prev & ~a) != 0)) begin m_st = 2; m_cnt = 0; end
                default: if (a == 0) m_st = 0;
                   else if (m_cnt == REL - 1) m_st = 1;
                   else m_cnt++;
            endcase
            m_prev = a;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s irq_n actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s release length actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished)
            check(m_st == 2 ? "R6" : (pulse_mode ? "R5" : "R3"), irq_n, (m_st != 1));
    end

    task automatic drive(input logic [3:0] f, input logic [3:0] e, input logic m);
        src_flag = f; src_en = e; pulse_mode = m;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (irq_n && n < 30000) begin n++; @(negedge clk); end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        int n, seed;
        seed = $urandom(32'h5EED_0042);
        wait_n(3);
        check("R1", irq_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1", irq_n, 1'b1);

        // R2: masked flags ignored, then one enable bit
        drive(4'b1111, 4'b0000, 1'b0); wait_n(3);
        check("R2", irq_n, 1'b1);
        drive(4'b1111, 4'b0100, 1'b0); @(negedge clk);
        check("R2", irq_n, 1'b0);

        // R3: level mode holds through partial clear
        drive(4'b0110, 4'b1111, 1'b0); wait_n(2);
        drive(4'b0100, 4'b1111, 1'b0);
        for (int i = 0; i < 20; i++) begin @(negedge clk); check("R3", irq_n, 1'b0); end

        // R5/R6: pulse mode partial clear
        drive(4'b0101, 4'b1111, 1'b1); wait_n(2);
        drive(4'b0100, 4'b1111, 1'b1); @(negedge clk);
        check("R5", irq_n, 1'b1);
        measure_high(n);
        check_int("R6", n, REL);
        check("R6", irq_n, 1'b0);

        // R7: activity inside a release does not change its length
        drive(4'b1100, 4'b1111, 1'b1); wait_n(2);
        drive(4'b0100, 4'b1111, 1'b1); @(negedge clk);
        n = 0;
        while (irq_n && n < 30000) begin
            if (n == 50)  drive(4'b0110, 4'b1111, 1'b1);
            if (n == 100) drive(4'b0100, 4'b1111, 1'b1);
            n++; @(negedge clk);
        end
        check_int("R7", n, REL);

        // R4: all cleared during a release, no reassert
        drive(4'b0110, 4'b1111, 1'b1); wait_n(2);
        drive(4'b0100, 4'b1111, 1'b1); wait_n(100);
        drive(4'b0000, 4'b1111, 1'b1); @(negedge clk);
        check("R4", irq_n, 1'b1);
        wait_n(REL + 100);
        check("R4", irq_n, 1'b1);

        // R8: dropping an enable bit acts as a clear
        drive(4'b0011, 4'b1111, 1'b1); wait_n(2);
        check("R8", irq_n, 1'b0);
        drive(4'b0011, 4'b1110, 1'b1); @(negedge clk);
        check("R8", irq_n, 1'b1);
        measure_high(n);
        check_int("R8", n, REL);

        // Random phase, checked every cycle against the model
        while (cyc < 180000) begin
            logic [3:0] f, e;
            f = 4'($urandom);
            e = ($urandom % 4 != 0) ? 4'hF : 4'($urandom);
            drive(f, e, ($urandom % 3) != 0);
            wait_n(1 + $urandom % 40);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule